// File: doc/BRIEF.md
# Fixed-Priority DMA Bus Arbiter

This block decides which of four DMA channels drives a shared bus. It also decides when the bus may move from one channel to another. Each channel raises a request line and reports its transfer style as a two-bit code on `ch_mode`. While it owns the bus, the channel pulses `ch_done` at the end of each transfer cycle and raises `ch_last` on the closing cycle of a burst or block. Another bus master, outside the DMA engine, has its own request line `ext_req`.

When the bus is idle, the lowest-numbered requesting channel wins. A channel that holds the bus keeps it until it releases the bus. A single-style channel releases after every transfer cycle. A burst-style or block-style channel releases only on the closing cycle. At the release point, the next owner is the lowest-numbered requester other than the current owner. If the outside master is requesting at that moment, it gets exactly one bus cycle before the next channel starts. All grants come from registers, so they change only at a rising clock edge, one cycle after the inputs that caused the change.

Top module: `dma_chan_arbiter`

## Requirements
- R1: A synchronous reset, held high over at least one rising edge, leaves `ch_grant` at zero, `ext_grant` low and `bus_busy` low in the cycle after reset is released.
- R2: While the bus is idle, one cycle after any channel requests, `ch_grant` shows exactly one bit, and that bit belongs to the lowest-numbered requesting channel (bit i is channel i). This holds whatever the state of `ext_req`.
- R3: While a channel owns the bus and does not release it, `ch_grant` stays unchanged, whatever the other channels request.
- R4: For an owner whose transfer code is 0 (single), a `ch_done` pulse releases the bus. The next owner is the lowest-numbered requester other than the owner. The owner is granted again only if it is the sole requester. If nobody requests, the bus goes idle one cycle after the release.
- R5: Codes 1 (burst), 2 (block) and 3 (treated as block) are captured when the channel is granted. For such an owner, `ch_done` without `ch_last` in the same cycle does not release the bus. This stays true even if `ch_mode` changes afterwards or a lower-numbered channel requests. `ch_done` together with `ch_last` does release it.
- R6: If `ext_req` is high at a release that has a next channel, `ext_grant` is high for exactly the following cycle. The chosen channel is granted in the cycle after that.
- R7: If `ext_req` is high when no channel requests, either at a release or while the bus is idle, `ext_grant` is high for one cycle. The bus then returns to idle.
- R8: At most one of the five grant outputs is high in any cycle, and `bus_busy` is high exactly when one of them is.
- R9: `ext_grant` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | NUM_CH | Request per channel |
| ch_mode | input | 2*NUM_CH | Transfer code per channel, channel i at bits [2i+1:2i]: 0 single, 1 burst, 2 block, 3 block |
| ch_done | input | NUM_CH | Per channel: the current transfer cycle ends this cycle |
| ch_last | input | NUM_CH | Per channel: this is the closing cycle of a burst or block |
| ext_req | input | 1 | Request from the outside bus master |
| ch_grant | output | NUM_CH | One-hot channel grant |
| ext_grant | output | 1 | Grant to the outside bus master, one cycle long |
| bus_busy | output | 1 | Bus owned by a channel or the outside master |

## Verification
The bench sweeps every request pattern against every owner, with and without an outside request at the release point. The point of the sweep is to catch a picker that lets the owner win against others, or that puts the owner back although others are waiting. An arbiter that fails to mask the owner would keep granting channel 0 to itself. One that skips the outside slot would show a channel grant where `ext_grant` is expected. Burst and block owners receive `ch_done` pulses without `ch_last`, with all channels requesting and the mode bits rewritten to single. A design that reads the live mode instead of the captured one would switch early. One that ignored `ch_last` would never switch.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        XFER_SINGLE = 2'd0,
        XFER_BURST  = 2'd1,
        XFER_BLOCK  = 2'd2,
        XFER_BLOCK2 = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_CHAN = 2'd1,
        ARB_EXT  = 2'd2
    } arb_state_e;

    // Any code other than single holds the bus until the closing cycle.
    function automatic logic holds_bus(input logic [MODE_W-1:0] code);
        return code != XFER_SINGLE;
    endfunction

endpackage

// File: rtl/dma_arb_prio_pick.sv
module dma_arb_prio_pick #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             vld,
    output logic [IDX_W-1:0] idx
);
    // Lowest index wins: the scan runs downwards so the last hit is the lowest.
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                vld = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_arb_grant_dec.sv
module dma_arb_grant_dec
    import dma_arb_pkg::*;
#(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  arb_state_e       st,
    input  logic [IDX_W-1:0] owner,
    output logic [N-1:0]     ch_grant,
    output logic             ext_grant,
    output logic             bus_busy
);
    for (genvar g = 0; g < N; g++) begin : g_grant
        assign ch_grant[g] = (st == ARB_CHAN) && (owner == IDX_W'(g));
    end
    assign ext_grant = (st == ARB_EXT);
    assign bus_busy  = (st != ARB_IDLE);
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        ch_req,
    input  logic [MODE_W*NUM_CH-1:0] ch_mode,
    input  logic [NUM_CH-1:0]        ch_done,
    input  logic [NUM_CH-1:0]        ch_last,
    input  logic                     ext_req,
    output logic [NUM_CH-1:0]        ch_grant,
    output logic                     ext_grant,
    output logic                     bus_busy
);
    arb_state_e       st_q;
    logic [CH_W-1:0]  own_q;
    logic             multi_q;
    logic [CH_W-1:0]  pend_q;
    logic             pend_vld_q;

    logic [NUM_CH-1:0] own_mask;
    logic [NUM_CH-1:0] pick_req;
    logic              o_vld;
    logic [CH_W-1:0]   o_idx;
    logic              owner_again;
    logic              nxt_vld;
    logic [CH_W-1:0]   nxt_idx;
    logic              release_now;

    function automatic logic [MODE_W-1:0] mode_at(input logic [CH_W-1:0] idx);
        return ch_mode[int'(idx)*MODE_W +: MODE_W];
    endfunction

    // The current owner is left out of the search for the next one.
    assign own_mask = (st_q == ARB_CHAN) ? (NUM_CH'(1) << own_q) : '0;
    assign pick_req = ch_req & ~own_mask;

    dma_arb_prio_pick #(.N(NUM_CH)) u_pick (
        .req (pick_req),
        .vld (o_vld),
        .idx (o_idx)
    );

    assign owner_again = (st_q == ARB_CHAN) && ch_req[own_q];
    assign nxt_vld     = o_vld || owner_again;
    assign nxt_idx     = o_vld ? o_idx : own_q;
    assign release_now = (st_q == ARB_CHAN) && ch_done[own_q]
                         && (!multi_q || ch_last[own_q]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ARB_IDLE;
            own_q      <= '0;
            multi_q    <= 1'b0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else begin
            unique case (st_q)
                ARB_IDLE: begin
                    if (o_vld) begin
                        st_q    <= ARB_CHAN;
                        own_q   <= o_idx;
                        multi_q <= holds_bus(mode_at(o_idx));
                    end else if (ext_req) begin
                        st_q       <= ARB_EXT;
                        pend_vld_q <= 1'b0;
                    end
                end
                ARB_CHAN: begin
                    if (release_now) begin
                        if (ext_req) begin
                            st_q       <= ARB_EXT;
                            pend_q     <= nxt_idx;
                            pend_vld_q <= nxt_vld;
                        end else if (nxt_vld) begin
                            own_q   <= nxt_idx;
                            multi_q <= holds_bus(mode_at(nxt_idx));
                        end else begin
                            st_q <= ARB_IDLE;
                        end
                    end
                end
                ARB_EXT: begin
                    pend_vld_q <= 1'b0;
                    if (pend_vld_q) begin
                        st_q    <= ARB_CHAN;
                        own_q   <= pend_q;
                        multi_q <= holds_bus(mode_at(pend_q));
                    end else begin
                        st_q <= ARB_IDLE;
                    end
                end
                default: st_q <= ARB_IDLE;
            endcase
        end
    end

    dma_arb_grant_dec #(.N(NUM_CH)) u_dec (
        .st        (st_q),
        .owner     (own_q),
        .ch_grant  (ch_grant),
        .ext_grant (ext_grant),
        .bus_busy  (bus_busy)
    );
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] ch_req,
    input logic [NUM_CH-1:0] ch_done,
    input logic [NUM_CH-1:0] ch_last,
    input logic [NUM_CH-1:0] ch_grant,
    input logic              ext_grant,
    input logic              bus_busy,
    input logic              owner_multi
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (ch_grant == '0 && !ext_grant && !bus_busy));

    assert_idle_grants_R2: assert property (@(posedge clk) disable iff (rst)
        (!bus_busy && |ch_req) |=> (|ch_grant));

    assert_hold_no_done_R3: assert property (@(posedge clk) disable iff (rst)
        (|ch_grant && !(|(ch_done & ch_grant))) |=> (ch_grant == $past(ch_grant)));

    assert_burst_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (|ch_grant && owner_multi && !(|(ch_last & ch_grant)))
            |=> (ch_grant == $past(ch_grant)));

    assert_one_grant_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ch_grant, ext_grant}));

    assert_busy_match_R8: assert property (@(posedge clk) disable iff (rst)
        bus_busy == (|{ch_grant, ext_grant}));

    assert_ext_single_R9: assert property (@(posedge clk) disable iff (rst)
        ext_grant |=> !ext_grant);
endmodule

bind dma_chan_arbiter dma_arb_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ch_req      (ch_req),
    .ch_done     (ch_done),
    .ch_last     (ch_last),
    .ch_grant    (ch_grant),
    .ext_grant   (ext_grant),
    .bus_busy    (bus_busy),
    .owner_multi (multi_q)
);

// File: tb/dma_chan_arbiter_tb.sv
module dma_chan_arbiter_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] ch_req = '0;
    logic [2*N-1:0] ch_mode = '0;
    logic [N-1:0] ch_done = '0;
    logic [N-1:0] ch_last = '0;
    logic         ext_req = 1'b0;
    logic [N-1:0] ch_grant;
    logic         ext_grant;
    logic         bus_busy;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dma_chan_arbiter #(.NUM_CH(N)) dut_i (
        .clk(clk), .rst(rst), .ch_req(ch_req), .ch_mode(ch_mode),
        .ch_done(ch_done), .ch_last(ch_last), .ext_req(ext_req),
        .ch_grant(ch_grant), .ext_grant(ext_grant), .bus_busy(bus_busy)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Applied to every sample: exclusivity and the meaning of bus_busy.
    task automatic chk_outs(input string tag, input logic [N-1:0] eg, input logic ee);
        chk(tag, {4'b0, ch_grant}, {4'b0, eg});
        chk(tag, {7'b0, ext_grant}, {7'b0, ee});
        chk("R8 busy", {7'b0, bus_busy}, {7'b0, (eg != 0) || ee});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; ch_req = '0; ch_mode = '0; ch_done = '0; ch_last = '0; ext_req = 1'b0;
        step();
        rst = 1'b0;
    endtask

    function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
        return v & (~v + 1'b1);
    endfunction

    task automatic own(input int c, input logic [1:0] m);
        ch_mode = 8'(m) << (2 * c);
        ch_req  = N'(1) << c;
        step();
        chk_outs("R2 acquire", N'(1) << c, 1'b0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk_outs("R1 reset", '0, 1'b0);

        // R2: idle grant picks the lowest index, outside request loses to channels
        for (int p = 1; p < 16; p++) begin
            for (int e = 0; e < 2; e++) begin
                do_reset();
                ch_req = N'(p); ext_req = e[0];
                step();
                chk_outs("R2 idle pick", lowest(N'(p)), 1'b0);
            end
        end

        // R7/R9: outside master alone while idle, one cycle then idle
        do_reset();
        ext_req = 1'b1;
        step();
        chk_outs("R7 idle ext", '0, 1'b1);
        step();
        chk_outs("R9 ext one cycle", '0, 1'b0);
        ext_req = 1'b0;

        // R3/R4/R6/R7: every owner, every request pattern, with and without outside request
        for (int c = 0; c < N; c++) begin
            for (int p = 0; p < 16; p++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [N-1:0] others, nxt;
                    do_reset();
                    own(c, 2'd0);
                    ch_req = N'(p);
                    step();
                    chk_outs("R3 hold", N'(1) << c, 1'b0);
                    others = N'(p) & ~(N'(1) << c);
                    nxt = (others != 0) ? lowest(others) : (N'(p) & (N'(1) << c));
                    ch_done = N'(1) << c; ext_req = e[0];
                    step();
                    ch_done = '0; ext_req = 1'b0;
                    if (e == 1) begin
                        chk_outs("R6 ext slot", '0, 1'b1);
                        step();
                        chk_outs((nxt != 0) ? "R6 after ext" : "R7 ext then idle", nxt, 1'b0);
                    end else begin
                        chk_outs("R4 single switch", nxt, 1'b0);
                    end
                end
            end
        end

        // R5: burst/block owners ignore done without last, even after mode rewrite
        for (int c = 0; c < N; c++) begin
            for (int m = 1; m < 4; m++) begin
                do_reset();
                own(c, 2'(m));
                ch_req = '1; ch_mode = '0; ch_done = N'(1) << c; ch_last = '0;
                for (int k = 0; k < 3; k++) begin
                    step();
                    chk_outs("R5 burst hold", N'(1) << c, 1'b0);
                end
                ch_last = N'(1) << c;
                step();
                ch_done = '0; ch_last = '0;
                chk_outs("R5 burst end", (c == 0) ? 4'b0010 : 4'b0001, 1'b0);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule